// File: doc/BRIEF.md
# Qualified Retire and Cycle Counters

This block keeps the two architectural event counters of a 32-bit RISC-V hart: a free-running cycle counter and a retired-instruction counter. Both are 64 bits wide and are seen by software as separate low and high 32-bit CSR halves. A counter-inhibit register decides whether each counter advances. Inhibit never affects reads or writes.

The pipeline controller presents a completion strobe for each instruction together with the final trap flags: illegal instruction, environment call, breakpoint, load access fault and store access fault. It also presents markers for debug-return and machine-return instructions, the current privilege (user or machine) and the debug-mode flag. From these the block decides whether the instruction really retired. An instruction that traps for any reason, including the cases that are illegal only because of privilege or debug state, does not advance the instruction count and does not commit a CSR write. A committed write to a counter half replaces the increment for that counter in the same cycle. The new value is visible from the next cycle.

Top module: `perf_retire_counters`

## Requirements
- R1: After synchronous reset, both 64-bit counters read zero and the inhibit register reads zero.
- R2: While inhibit bit 0 is clear, the cycle counter increases by one every clock. While that bit is set, it holds its value.
- R3: The retired-instruction counter increases by one in a cycle where `done_i` is high, no trap condition holds and inhibit bit 2 is clear. Otherwise it holds. `retired_o` shows that qualification in the same cycle.
- R4: Any of `exc_illegal_i`, `exc_ecall_i`, `exc_ebreak_i`, `exc_ld_fault_i` or `exc_st_fault_i` suppresses retirement.
- R5: `is_dret_i` without `debug_mode_i` suppresses retirement, and so does `is_mret_i` with `priv_user_i`. In debug mode, or in machine mode respectively, they retire.
- R6: A CSR write with `csr_we_i` in a retiring cycle loads the addressed half with `csr_wdata_i`. The addresses are 0xB00 (cycle low), 0xB80 (cycle high), 0xB02 (instret low) and 0xB82 (instret high). The other half is unchanged, and the written counter does not also increment in that cycle. A write in a non-retiring cycle is dropped.
- R7: A write with `priv_user_i` high to any address owned by this block is illegal. It is dropped and the instruction does not retire.
- R8: A carry out of a low half increments the high half on the same clock edge.
- R9: The inhibit register is at address 0x320 and stores only bit 0 (cycle) and bit 2 (instret). All other bits read zero.
- R10: `csr_rdata_o` returns the addressed half or the inhibit register combinationally, and returns zero for any other address.
- R11: Writes to a counter take effect even while that counter's inhibit bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Instruction completes this cycle |
| exc_illegal_i | input | 1 | Final illegal-instruction decision from controller |
| exc_ecall_i | input | 1 | Environment call |
| exc_ebreak_i | input | 1 | Breakpoint |
| exc_ld_fault_i | input | 1 | Load access fault |
| exc_st_fault_i | input | 1 | Store access fault |
| is_dret_i | input | 1 | Instruction is a debug return |
| is_mret_i | input | 1 | Instruction is a machine return |
| priv_user_i | input | 1 | Hart is in user mode |
| debug_mode_i | input | 1 | Hart is in debug mode |
| csr_we_i | input | 1 | Instruction writes a CSR |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data |
| retired_o | output | 1 | Qualified retirement this cycle |
| cycle_lo_o | output | 32 | Cycle counter low half |
| cycle_hi_o | output | 32 | Cycle counter high half |
| instret_lo_o | output | 32 | Instret counter low half |
| instret_hi_o | output | 32 | Instret counter high half |
| inhibit_o | output | 32 | Counter-inhibit register |

## Verification
A wrong retirement decision shows up on `retired_o` in the same cycle. The instret halves then drift from the expected count one clock later, and the error is never corrected afterwards. A broken write priority or carry path shows as a counter that is off by one, or a stale half, on the first clock after the write or wrap. Sweeping every combination of trap, privilege and debug inputs exposes a missing term in the qualifier as soon as that combination is applied.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam logic [11:0] ADDR_CYC_LO = 12'hB00;
  localparam logic [11:0] ADDR_CYC_HI = 12'hB80;
  localparam logic [11:0] ADDR_RET_LO = 12'hB02;
  localparam logic [11:0] ADDR_RET_HI = 12'hB82;
  localparam logic [11:0] ADDR_INHIB  = 12'h320;
  localparam int          BIT_CY      = 0;
  localparam int          BIT_IR      = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CYC_LO, SEL_CYC_HI, SEL_RET_LO, SEL_RET_HI, SEL_INHIB
  } csr_sel_e;

  function automatic csr_sel_e decode_addr(input logic [11:0] a);
    case (a)
      ADDR_CYC_LO: decode_addr = SEL_CYC_LO;
      ADDR_CYC_HI: decode_addr = SEL_CYC_HI;
      ADDR_RET_LO: decode_addr = SEL_RET_LO;
      ADDR_RET_HI: decode_addr = SEL_RET_HI;
      ADDR_INHIB:  decode_addr = SEL_INHIB;
      default:     decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rcc_retire_qual.sv
module rcc_retire_qual
  import rcc_pkg::*;
(
  input  logic       done_i,
  input  logic       exc_illegal_i,
  input  logic       exc_ecall_i,
  input  logic       exc_ebreak_i,
  input  logic       exc_ld_fault_i,
  input  logic       exc_st_fault_i,
  input  logic       is_dret_i,
  input  logic       is_mret_i,
  input  logic       priv_user_i,
  input  logic       debug_mode_i,
  input  logic       csr_we_i,
  input  csr_sel_e   csr_sel_i,
  output logic       retired_o,
  output logic       commit_wr_o
);
  logic sync_trap, dret_bad, mret_bad, csr_bad, any_trap;

  always_comb begin
    sync_trap = exc_illegal_i | exc_ecall_i | exc_ebreak_i |
                exc_ld_fault_i | exc_st_fault_i;
    dret_bad  = is_dret_i & ~debug_mode_i;
    mret_bad  = is_mret_i & priv_user_i;
    csr_bad   = csr_we_i & (csr_sel_i != SEL_NONE) & priv_user_i;
    any_trap  = sync_trap | dret_bad | mret_bad | csr_bad;
    retired_o = done_i & ~any_trap;
    commit_wr_o = retired_o & csr_we_i & (csr_sel_i != SEL_NONE);
  end
endmodule

// File: rtl/rcc_counter.sv
module rcc_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  localparam int CTR_W = 2 * HALF_W;
  logic [CTR_W-1:0] nxt;

  always_comb nxt = {hi_o, lo_o} + {{(CTR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (wr_lo_i) begin
      lo_o <= wdata_i;
    end else if (wr_hi_i) begin
      hi_o <= wdata_i;
    end else if (inc_i) begin
      lo_o <= nxt[HALF_W-1:0];
      hi_o <= nxt[CTR_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/rcc_inhibit.sv
module rcc_inhibit
  import rcc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] inhibit_o
);
  localparam logic [XLEN-1:0] KEEP_MASK =
    (XLEN'(1) << BIT_CY) | (XLEN'(1) << BIT_IR);

  always_ff @(posedge clk) begin
    if (rst)       inhibit_o <= '0;
    else if (wr_i) inhibit_o <= wdata_i & KEEP_MASK;
  end
endmodule

// File: rtl/perf_retire_counters.sv
module perf_retire_counters
  import rcc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            done_i,
  input  logic            exc_illegal_i,
  input  logic            exc_ecall_i,
  input  logic            exc_ebreak_i,
  input  logic            exc_ld_fault_i,
  input  logic            exc_st_fault_i,
  input  logic            is_dret_i,
  input  logic            is_mret_i,
  input  logic            priv_user_i,
  input  logic            debug_mode_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            retired_o,
  output logic [XLEN-1:0] cycle_lo_o,
  output logic [XLEN-1:0] cycle_hi_o,
  output logic [XLEN-1:0] instret_lo_o,
  output logic [XLEN-1:0] instret_hi_o,
  output logic [XLEN-1:0] inhibit_o
);
  csr_sel_e sel;
  logic     commit_wr;

  always_comb sel = decode_addr(csr_addr_i);

  rcc_retire_qual u_qual (
    .done_i        (done_i),
    .exc_illegal_i (exc_illegal_i),
    .exc_ecall_i   (exc_ecall_i),
    .exc_ebreak_i  (exc_ebreak_i),
    .exc_ld_fault_i(exc_ld_fault_i),
    .exc_st_fault_i(exc_st_fault_i),
    .is_dret_i     (is_dret_i),
    .is_mret_i     (is_mret_i),
    .priv_user_i   (priv_user_i),
    .debug_mode_i  (debug_mode_i),
    .csr_we_i      (csr_we_i),
    .csr_sel_i     (sel),
    .retired_o     (retired_o),
    .commit_wr_o   (commit_wr)
  );

  rcc_counter #(.HALF_W(XLEN)) u_cycle (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (~inhibit_o[BIT_CY]),
    .wr_lo_i (commit_wr & (sel == SEL_CYC_LO)),
    .wr_hi_i (commit_wr & (sel == SEL_CYC_HI)),
    .wdata_i (csr_wdata_i),
    .lo_o    (cycle_lo_o),
    .hi_o    (cycle_hi_o)
  );

  rcc_counter #(.HALF_W(XLEN)) u_instret (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (retired_o & ~inhibit_o[BIT_IR]),
    .wr_lo_i (commit_wr & (sel == SEL_RET_LO)),
    .wr_hi_i (commit_wr & (sel == SEL_RET_HI)),
    .wdata_i (csr_wdata_i),
    .lo_o    (instret_lo_o),
    .hi_o    (instret_hi_o)
  );

  rcc_inhibit #(.XLEN(XLEN)) u_inhib (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (commit_wr & (sel == SEL_INHIB)),
    .wdata_i  (csr_wdata_i),
    .inhibit_o(inhibit_o)
  );

  always_comb begin
    case (sel)
      SEL_CYC_LO: csr_rdata_o = cycle_lo_o;
      SEL_CYC_HI: csr_rdata_o = cycle_hi_o;
      SEL_RET_LO: csr_rdata_o = instret_lo_o;
      SEL_RET_HI: csr_rdata_o = instret_hi_o;
      SEL_INHIB:  csr_rdata_o = inhibit_o;
      default:    csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/perf_retire_counters_chk.sv
module perf_retire_counters_chk
  import rcc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        done_i,
  input logic        exc_illegal_i,
  input logic        exc_ecall_i,
  input logic        exc_ebreak_i,
  input logic        exc_ld_fault_i,
  input logic        exc_st_fault_i,
  input logic        is_dret_i,
  input logic        is_mret_i,
  input logic        priv_user_i,
  input logic        debug_mode_i,
  input logic        csr_we_i,
  input logic [11:0] csr_addr_i,
  input logic [31:0] csr_wdata_i,
  input logic        retired_o,
  input logic [31:0] cycle_lo_o,
  input logic [31:0] cycle_hi_o,
  input logic [31:0] instret_lo_o,
  input logic [31:0] instret_hi_o,
  input logic [31:0] inhibit_o
);
  logic wr_cyc, wr_ret, wr_ret_lo;
  always_comb begin
    wr_cyc    = retired_o & csr_we_i &
                (csr_addr_i == ADDR_CYC_LO || csr_addr_i == ADDR_CYC_HI);
    wr_ret    = retired_o & csr_we_i &
                (csr_addr_i == ADDR_RET_LO || csr_addr_i == ADDR_RET_HI);
    wr_ret_lo = retired_o & csr_we_i & (csr_addr_i == ADDR_RET_LO);
  end

  // R4
  trap_blocks_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_illegal_i || exc_ecall_i || exc_ebreak_i || exc_ld_fault_i || exc_st_fault_i)
    |-> !retired_o);

  // R5
  dret_outside_debug_chk: assert property (@(posedge clk) disable iff (rst)
    (is_dret_i && !debug_mode_i) |-> !retired_o);

  // R5
  mret_in_user_chk: assert property (@(posedge clk) disable iff (rst)
    (is_mret_i && priv_user_i) |-> !retired_o);

  // R7
  user_csr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we_i && priv_user_i && (csr_addr_i == ADDR_RET_LO || csr_addr_i == ADDR_INHIB))
    |-> !retired_o);

  // R3
  instret_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!retired_o && !wr_ret) |=>
    ({instret_hi_o, instret_lo_o} == $past({instret_hi_o, instret_lo_o})));

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_o[BIT_CY] && !wr_cyc) |=>
    ({cycle_hi_o, cycle_lo_o} == $past({cycle_hi_o, cycle_lo_o}) + 64'd1));

  // R2
  cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit_o[BIT_CY] && !wr_cyc) |=>
    $stable({cycle_hi_o, cycle_lo_o}));

  // R6
  instret_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ret_lo |=> (instret_lo_o == $past(csr_wdata_i)) &&
                  (instret_hi_o == $past(instret_hi_o)));

  // R9
  inhibit_warl_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit_o[1] == 1'b0) && (inhibit_o[31:3] == 29'd0));
endmodule

bind perf_retire_counters perf_retire_counters_chk u_chk (
  .clk(clk), .rst(rst), .done_i(done_i), .exc_illegal_i(exc_illegal_i),
  .exc_ecall_i(exc_ecall_i), .exc_ebreak_i(exc_ebreak_i),
  .exc_ld_fault_i(exc_ld_fault_i), .exc_st_fault_i(exc_st_fault_i),
  .is_dret_i(is_dret_i), .is_mret_i(is_mret_i), .priv_user_i(priv_user_i),
  .debug_mode_i(debug_mode_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
  .csr_wdata_i(csr_wdata_i), .retired_o(retired_o), .cycle_lo_o(cycle_lo_o),
  .cycle_hi_o(cycle_hi_o), .instret_lo_o(instret_lo_o),
  .instret_hi_o(instret_hi_o), .inhibit_o(inhibit_o)
);

// File: tb/perf_retire_counters_bench.sv
`timescale 1ns/1ps
module perf_retire_counters_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, done_i, exc_illegal_i, exc_ecall_i, exc_ebreak_i;
  logic        exc_ld_fault_i, exc_st_fault_i, is_dret_i, is_mret_i;
  logic        priv_user_i, debug_mode_i, csr_we_i;
  logic [11:0] csr_addr_i;
  logic [31:0] csr_wdata_i, csr_rdata_o;
  logic        retired_o;
  logic [31:0] cycle_lo_o, cycle_hi_o, instret_lo_o, instret_hi_o, inhibit_o;

  perf_retire_counters u_perf_retire_counters (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_cyc, m_ret;
  logic [31:0] m_inh;

  function automatic logic mapped(input logic [11:0] a);
    return a == 12'hB00 || a == 12'hB80 || a == 12'hB02 ||
           a == 12'hB82 || a == 12'h320;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'hB00: return m_cyc[31:0];
      12'hB80: return m_cyc[63:32];
      12'hB02: return m_ret[31:0];
      12'hB82: return m_ret[63:32];
      12'h320: return m_inh;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags: [0]illegal [1]ecall [2]ebreak [3]ld [4]st [5]dret [6]mret [7]user [8]debug
  task automatic step(input string req, input logic d, input logic [8:0] f,
                      input logic we, input logic [11:0] a, input logic [31:0] wd);
    logic r, commit;
    done_i = d;
    {debug_mode_i, priv_user_i, is_mret_i, is_dret_i, exc_st_fault_i,
     exc_ld_fault_i, exc_ebreak_i, exc_ecall_i, exc_illegal_i} = f;
    csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd;
    #1;
    r = d & ~(|f[4:0]) & ~(f[5] & ~f[8]) & ~(f[6] & f[7]) & ~(we & mapped(a) & f[7]);
    check({req, " retired"}, {63'd0, retired_o}, {63'd0, r});
    check({req, " rdata"}, {32'd0, csr_rdata_o}, {32'd0, exp_rd(a)});
    commit = r & we & mapped(a);
    @(posedge clk);
    if (commit && a == 12'hB00)      m_cyc[31:0]  = wd;
    else if (commit && a == 12'hB80) m_cyc[63:32] = wd;
    else if (!m_inh[0])              m_cyc = m_cyc + 64'd1;
    if (commit && a == 12'hB02)      m_ret[31:0]  = wd;
    else if (commit && a == 12'hB82) m_ret[63:32] = wd;
    else if (r && !m_inh[2])         m_ret = m_ret + 64'd1;
    if (commit && a == 12'h320)      m_inh = wd & 32'h5;
    @(negedge clk);
    check({req, " cycle"}, {cycle_hi_o, cycle_lo_o}, m_cyc);
    check({req, " instret"}, {instret_hi_o, instret_lo_o}, m_ret);
    check({req, " inhibit"}, {32'd0, inhibit_o}, {32'd0, m_inh});
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    done_i = 0; exc_illegal_i = 0; exc_ecall_i = 0; exc_ebreak_i = 0;
    exc_ld_fault_i = 0; exc_st_fault_i = 0; is_dret_i = 0; is_mret_i = 0;
    priv_user_i = 0; debug_mode_i = 0; csr_we_i = 0;
    csr_addr_i = 12'h0; csr_wdata_i = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_cyc = 64'd0; m_ret = 64'd0; m_inh = 32'd0;
    // R1 reset state
    check("R1 cycle", {cycle_hi_o, cycle_lo_o}, 64'd0);
    check("R1 instret", {instret_hi_o, instret_lo_o}, 64'd0);
    check("R1 inhibit", {32'd0, inhibit_o}, 64'd0);

    // R3 R4 R5: every trap/privilege/debug combination, with and without completion
    for (int v = 0; v < 1024; v++)
      step("R4 R5 R3 sweep", v[9], v[8:0], 1'b0, 12'hB02, 32'h0);

    // R9 R2 R3: inhibit values with garbage in unimplemented bits
    for (int v = 0; v < 8; v++) begin
      step("R9 inhibit write", 1'b1, 9'd0, 1'b1, 12'h320, 32'hFFFF_FFF8 | v);
      for (int k = 0; k < 3; k++)
        step("R2 R3 inhibit effect", 1'b1, 9'd0, 1'b0, 12'h320, 32'h0);
    end
    step("R9 clear", 1'b1, 9'd0, 1'b1, 12'h320, 32'h0);

    // R6 R8: low-half write then carry
    step("R6 instret lo write", 1'b1, 9'd0, 1'b1, 12'hB02, 32'hFFFF_FFFE);
    for (int k = 0; k < 3; k++)
      step("R8 instret carry", 1'b1, 9'd0, 1'b0, 12'hB82, 32'h0);
    step("R6 cycle lo write", 1'b1, 9'd0, 1'b1, 12'hB00, 32'hFFFF_FFFF);
    step("R8 cycle carry", 1'b0, 9'd0, 1'b0, 12'hB80, 32'h0);
    step("R6 instret hi write", 1'b1, 9'd0, 1'b1, 12'hB82, 32'hA5A5_0001);
    step("R6 cycle hi write", 1'b1, 9'd0, 1'b1, 12'hB80, 32'h1234_5678);
    // R6 dropped write in a trapping cycle
    step("R6 ecall write dropped", 1'b1, 9'b0_0000_0010, 1'b1, 12'hB02, 32'hDEAD_BEEF);
    step("R6 no-done write dropped", 1'b0, 9'd0, 1'b1, 12'hB00, 32'hDEAD_BEEF);
    // R7 user-mode writes dropped and not retired
    step("R7 user write instret", 1'b1, 9'b0_1000_0000, 1'b1, 12'hB02, 32'h0);
    step("R7 user write inhibit", 1'b1, 9'b0_1000_0000, 1'b1, 12'h320, 32'h5);
    step("R7 user plain retire", 1'b1, 9'b0_1000_0000, 1'b0, 12'hB02, 32'h0);
    // R11 writes under inhibit
    step("R11 inhibit both", 1'b1, 9'd0, 1'b1, 12'h320, 32'h5);
    step("R11 write cycle", 1'b1, 9'd0, 1'b1, 12'hB00, 32'h0000_0042);
    step("R11 write instret", 1'b1, 9'd0, 1'b1, 12'hB02, 32'h0000_0077);
    step("R11 hold", 1'b1, 9'd0, 1'b0, 12'hB00, 32'h0);
    step("R11 release", 1'b1, 9'd0, 1'b1, 12'h320, 32'h0);
    // R10 reads across addresses including unmapped ones
    for (int k = 0; k < 8; k++) begin
      step("R10 read map", 1'b1, 9'd0, 1'b0,
           (k == 0) ? 12'hB00 : (k == 1) ? 12'hB80 : (k == 2) ? 12'hB02 :
           (k == 3) ? 12'hB82 : (k == 4) ? 12'h320 : (k == 5) ? 12'h123 :
           (k == 6) ? 12'hB01 : 12'hC00, 32'h0);
    end
    step("R10 unmapped write ignored", 1'b1, 9'd0, 1'b1, 12'h321, 32'hFFFF_FFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule